// File: doc/BRIEF.md
# Multicycle Capture Enable Controller

This block turns the path from a launch register to a capture register into a path that is allowed N clock edges to settle. A launch request loads a word into the launch register and restarts a phase counter. When the counter reaches its final phase, the capture side is allowed to sample, so the word arrives at the capture register exactly N capture-clock edges after the edge that launched it. The block never samples on the launching edge, so the hold requirement is zero cycles.

Two capture styles are chosen by a parameter. In the data-gating style the capture register runs on the free clock and reloads only while the enable is high, holding its value otherwise. In the clock-gating style the enable is retimed by a register on the falling clock edge, and the capture register is clocked by the AND of the clock and that register, so it receives one full-width pulse per capture and none at any other time. A launch source running at half the capture rate is served with N = 2.

Top module: `mcp_capture_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, capture_data is all zeros and capture_valid, capture_en and gated_clk are low.
- R2: A word launched on clock edge k (launch_valid high at that edge) appears on capture_data after edge k+N, and not before; N is the PERIOD parameter (2 to 16).
- R3: capture_valid is high for exactly the one clock cycle that follows each capture edge, once per effective launch, and is low in every other cycle.
- R4: Between captures capture_data keeps its value for at least N cycles; it changes only after a capture edge.
- R5: A launch that arrives before the previous word was captured restarts the phase count; only the newest word is captured, N edges after its own launch.
- R6: A launch on the same edge that captures the previous word does not disturb that capture (zero-cycle hold): the older word is captured on that edge and the new word N edges later, so launches every N cycles (N = 2 for a half-rate source) all arrive in order.
- R7: In the clock-gating style, gated_clk gives exactly one pulse for each capture and no other pulse, is high only while clk is high, and its enable changes only on falling edges.
- R8: launch_data has no effect on any output while launch_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock; the launch register also runs on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| launch_valid | input | 1 | Loads launch_data and restarts the phase count |
| launch_data | input | WIDTH | Word to be carried over the multicycle path |
| capture_data | output | WIDTH | Content of the capture register |
| capture_valid | output | 1 | One-cycle pulse after each capture edge |
| capture_en | output | 1 | Capture enable (falling-edge retimed in clock-gating style) |
| gated_clk | output | 1 | Gated capture clock; held low in data-gating style |

## Verification
Three copies run side by side on one launch stream: data gating with N = 3, clock gating with N = 4 and data gating with N = 2. Isolated launches show the exact N-edge latency; a second launch one cycle after the first separates a restarting counter from a free-running one, since N = 3 and 4 must drop the first word while N = 2 keeps it. Launches spaced exactly N apart and launches on every cycle tell a correct zero-cycle hold from one that samples the new word, and changing launch_data while launch_valid is low shows that only loaded words ever reach the output. For the gated copy the pulses of gated_clk are counted every cycle against the expected captures.

// File: rtl/mcp_pkg.sv
package mcp_pkg;
  typedef enum logic {
    MODE_DATA_GATE  = 1'b0,
    MODE_CLOCK_GATE = 1'b1
  } cap_mode_e;
endpackage

// File: rtl/mcp_reset_sync.sv
module mcp_reset_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/mcp_phase_ctr.sv
module mcp_phase_ctr #(
  parameter int PERIOD = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  output logic fire_o
);
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;

  assign fire_o = pend_q && (cnt_q == LAST);

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    if (launch_i) begin
      cnt_d  = '0;
      pend_d = 1'b1;
    end else if (fire_o) begin
      cnt_d  = '0;
      pend_d = 1'b0;
    end else if (pend_q) begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  // R5
  restart_on_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i |=> (cnt_q == '0) && pend_q);

  // R2
  phase_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/mcp_capture_stage.sv
module mcp_capture_stage #(
  parameter int                WIDTH = 8,
  parameter mcp_pkg::cap_mode_e MODE = mcp_pkg::MODE_DATA_GATE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             cap_en_o,
  output logic             gclk_o,
  output logic [WIDTH-1:0] data_o
);
  logic [WIDTH-1:0] cap_q;

  generate
    if (MODE == mcp_pkg::MODE_DATA_GATE) begin : g_data_gate
      logic [WIDTH-1:0] cap_d;

      always_comb begin
        cap_d = cap_q;
        if (fire_i) cap_d = data_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
      end

      assign cap_en_o = fire_i;
      assign gclk_o   = 1'b0;

      // R4
      hold_without_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_i |=> $stable(cap_q));
    end else begin : g_clock_gate
      logic en_q;

      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= fire_i;
      end

      assign gclk_o = clk & en_q;

      always_ff @(posedge gclk_o or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= data_i;
      end

      assign cap_en_o = en_q;

      // R7
      single_gate_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> !en_q);
    end
  endgenerate

  assign data_o = cap_q;
endmodule

// File: rtl/mcp_capture_ctrl.sv
module mcp_capture_ctrl #(
  parameter int                 WIDTH  = 8,
  parameter int                 PERIOD = 3,
  parameter mcp_pkg::cap_mode_e MODE   = mcp_pkg::MODE_DATA_GATE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_valid,
  input  logic [WIDTH-1:0] launch_data,
  output logic [WIDTH-1:0] capture_data,
  output logic             capture_valid,
  output logic             capture_en,
  output logic             gated_clk
);
  logic             srst_n;
  logic             fire;
  logic [WIDTH-1:0] launch_q, launch_d;
  logic             valid_q;

  mcp_reset_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  always_comb begin
    launch_d = launch_q;
    if (launch_valid) launch_d = launch_data;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      launch_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      launch_q <= launch_d;
      valid_q  <= fire;
    end
  end

  mcp_phase_ctr #(.PERIOD(PERIOD)) u_ctr (
    .clk      (clk),
    .rst_n    (srst_n),
    .launch_i (launch_valid),
    .fire_o   (fire)
  );

  mcp_capture_stage #(.WIDTH(WIDTH), .MODE(MODE)) u_cap (
    .clk      (clk),
    .rst_n    (srst_n),
    .fire_i   (fire),
    .data_i   (launch_q),
    .cap_en_o (capture_en),
    .gclk_o   (gated_clk),
    .data_o   (capture_data)
  );

  assign capture_valid = valid_q;

  // R3
  valid_single_cycle_chk: assert property (@(posedge clk) disable iff (!srst_n)
    capture_valid |=> !capture_valid);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !srst_n |-> (!capture_valid && (capture_data == '0)));
endmodule

// File: tb/mcp_capture_ctrl_bench.sv
module mcp_capture_ctrl_bench;
  localparam int W = 8;
  localparam int NI = 3;
  localparam int PER [NI] = '{3, 4, 2};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         launch_valid = 1'b0;
  logic [W-1:0] launch_data = '0;
  logic [W-1:0] dat [NI];
  logic         vld [NI];
  logic         cen [NI];
  logic         gck [NI];

  always #5 clk = ~clk;

  mcp_capture_ctrl #(.WIDTH(W), .PERIOD(3), .MODE(mcp_pkg::MODE_DATA_GATE)) u_mcp_capture_ctrl (
    .clk(clk), .rst_n(rst_n), .launch_valid(launch_valid), .launch_data(launch_data),
    .capture_data(dat[0]), .capture_valid(vld[0]), .capture_en(cen[0]), .gated_clk(gck[0]));

  mcp_capture_ctrl #(.WIDTH(W), .PERIOD(4), .MODE(mcp_pkg::MODE_CLOCK_GATE)) u_mcp_capture_ctrl_gated (
    .clk(clk), .rst_n(rst_n), .launch_valid(launch_valid), .launch_data(launch_data),
    .capture_data(dat[1]), .capture_valid(vld[1]), .capture_en(cen[1]), .gated_clk(gck[1]));

  mcp_capture_ctrl #(.WIDTH(W), .PERIOD(2), .MODE(mcp_pkg::MODE_DATA_GATE)) u_mcp_capture_ctrl_half (
    .clk(clk), .rst_n(rst_n), .launch_valid(launch_valid), .launch_data(launch_data),
    .capture_data(dat[2]), .capture_valid(vld[2]), .capture_en(cen[2]), .gated_clk(gck[2]));

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit running = 1'b0;
  int gpulses = 0;
  int       due_q [NI][$];
  logic [W-1:0] word_q [NI][$];
  logic [W-1:0] last [NI];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge gck[1]) gpulses <= gpulses + 1;

  // driver: one launch, with scoreboard push
  task automatic launch(input logic [W-1:0] w);
    @(negedge clk);
    launch_valid = 1'b1;
    launch_data  = w;
    @(posedge clk);
    #1;
    for (int i = 0; i < NI; i++) begin
      // R5: an outstanding word not yet captured is superseded
      while (due_q[i].size() > 0 && due_q[i][$] > cyc) begin
        void'(due_q[i].pop_back());
        void'(word_q[i].pop_back());
      end
      due_q[i].push_back(cyc + PER[i]);
      word_q[i].push_back(w);
    end
  endtask

  // idle cycles with launch_data changing (R8)
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      launch_valid = 1'b0;
      launch_data  = launch_data ^ 8'h5A ^ 8'(k);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (running) begin
      for (int i = 0; i < NI; i++) begin
        if (due_q[i].size() > 0 && due_q[i][0] == cyc) begin
          // R2, R6
          check(vld[i] == 1'b1, "R3", $sformatf("valid on capture inst%0d", i), vld[i], 1);
          check(dat[i] == word_q[i][0], "R2", $sformatf("captured word inst%0d", i), dat[i], word_q[i][0]);
          last[i] = word_q[i][0];
          void'(due_q[i].pop_front());
          void'(word_q[i].pop_front());
          if (i == 1) check(gpulses == 1, "R7", "gated pulse on capture", gpulses, 1);
        end else begin
          check(vld[i] == 1'b0, "R3", $sformatf("no valid inst%0d", i), vld[i], 0);
          // R4, R8
          check(dat[i] == last[i], "R4", $sformatf("capture held inst%0d", i), dat[i], last[i]);
          if (i == 1) check(gpulses == 0, "R7", "no gated pulse", gpulses, 0);
        end
      end
      check(gck[1] == 1'b0, "R7", "gated clock low while clk low", gck[1], 0);
      gpulses = 0;
    end
  end

  initial begin
    for (int i = 0; i < NI; i++) last[i] = '0;
    #12;
    for (int i = 0; i < NI; i++) begin
      check(dat[i] == '0, "R1", $sformatf("reset data inst%0d", i), dat[i], 0);
      check(vld[i] == 1'b0 && cen[i] == 1'b0 && gck[i] == 1'b0, "R1",
            $sformatf("reset controls inst%0d", i), {vld[i], cen[i], gck[i]}, 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    gpulses = 0;
    running = 1'b1;

    launch(8'hA5); idle(7);                       // R2 single launch
    launch(8'h3C); idle(1); launch(8'hC3); idle(7); // R5 relaunch (kept for N=2, R6)
    launch(8'h00); idle(7);
    for (int k = 0; k < 6; k++) begin launch(8'(8'h10 + k)); idle(1); end  // R6 half rate
    idle(6);
    for (int k = 0; k < 5; k++) begin launch(8'(8'h40 + k)); idle(2); end  // N=3 spacing
    idle(6);
    for (int k = 0; k < 4; k++) begin launch(8'(8'h80 + k)); idle(3); end  // N=4 spacing
    idle(6);
    for (int k = 0; k < 5; k++) launch(8'(8'hF0 + k));                     // R5 every cycle
    idle(8);
    launch(8'hFF); idle(10);                                                 // R8 noisy idle
    running = 1'b0;
    for (int i = 0; i < NI; i++)
      check(due_q[i].size() == 0, "R2", $sformatf("pending words inst%0d", i), due_q[i].size(), 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #200000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule